// File: doc/BRIEF.md
# Teletext Line Insertion Window Controller

This block produces the timing an external teletext source needs to place its data on chosen video lines. At each line start, the raster timing supplies a strobe together with the line number and a flag that says whether the current field is even. The block decides whether the line carries teletext by testing three things:

- the line number against a start/end range programmed for the current field (odd and even fields each have their own range);
- a per-line enable mask;
- whether the line lies inside the mask's coverage.

A mask bit counts only on a line that is already inside the range for its field.

On a qualifying line a pixel counter runs from the line strobe. A request toward the teletext source rises a programmable number of pixel clocks before the insertion window opens, which gives the source time to fill its pipeline. The window gate opens at a programmable pixel position. It stays open for exactly 360 teletext bit periods, a count that includes the clock run-in. Bit periods come from a 16-bit phase accumulator with a programmable increment, advanced at pixel rate. A window that would pass the end of the active line is cut off there, and a new line strobe discards any remaining part of a window.

Top module: `ttx_insert_ctrl`

## Requirements
- R1: While reset is low, and after its release until the next qualifying line strobe, `ttx_req`, `ttx_gate` and `ttx_bit_tick` are all 0.
- R2: On an odd field (`field_even`=0), a line qualifies when `odd_first` <= `line_no` <= `odd_last` and its mask bit is set. The mask bit for line n is `line_mask[n-MASK_BASE]`, with MASK_BASE=5 by default.
- R3: On an even field (`field_even`=1), only `even_first`..`even_last` bounds the lines; the odd range has no effect, and the reverse also holds.
- R4: A set mask bit has no effect on a line outside the current field's range. A clear mask bit disables a line inside the range. Lines outside the mask coverage (below MASK_BASE or at MASK_BASE+MASK_LINES and above) never qualify.
- R5: With first > last for a field, no line of that field qualifies. With first == last, exactly that line qualifies.
- R6: The pixel index is 0 in the cycle after the strobe edge. On a qualifying line, `ttx_gate` rises at pixel `win_open`. `ttx_req` rises at pixel `win_open`-`req_lead`, or at pixel 0 when `req_lead` > `win_open`.
- R7: The window lasts until 360 bit ticks have occurred; the tick at which the count reaches 360 falls in the last gate cycle. No line yields more than 360 ticks.
- R8: The accumulator is cleared at each strobe and adds `bit_step` (mod 2^16) in each gate cycle. `ttx_bit_tick` is high in the cycles where that addition carries, so n gate cycles give floor(n*`bit_step`/65536) ticks.
- R9: The gate and the request are low at every pixel >= `line_len`. A strobe ends any open window, and the new line starts from pixel 0 with a cleared accumulator and bit count.
- R10: `ttx_req` stays high from its rise until the window closes, and falls in the same cycle as `ttx_gate`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_strobe | input | 1 | One-cycle pulse at the start of each line |
| line_no | input | LINE_W | Line number, sampled with the strobe |
| field_even | input | 1 | 1 for an even field, 0 for an odd field, sampled with the strobe |
| odd_first | input | LINE_W | First eligible line of odd fields |
| odd_last | input | LINE_W | Last eligible line of odd fields |
| even_first | input | LINE_W | First eligible line of even fields |
| even_last | input | LINE_W | Last eligible line of even fields |
| line_mask | input | MASK_LINES | Per-line enable, bit i for line MASK_BASE+i |
| req_lead | input | PIX_W | Pixel clocks by which the request precedes the window |
| win_open | input | PIX_W | Pixel index at which the window opens |
| line_len | input | PIX_W | Active line length in pixels; the window is cut at this index |
| bit_step | input | ACC_W | Phase accumulator increment per pixel clock |
| ttx_req | output | 1 | Data request to the teletext source |
| ttx_gate | output | 1 | Insertion window gate |
| ttx_bit_tick | output | 1 | One-cycle teletext bit tick inside the window |

## Verification
All three outputs are decoded from state registered at the strobe edge. The first falling edge after that edge therefore shows pixel 0, and each later falling edge advances one pixel. The bench drives the strobe at a falling edge and samples every output at each following falling edge. The sample index is then exactly the pixel index, and no result waits an extra cycle. From these samples it counts request cycles, gate cycles and ticks, and records the first request and gate pixels. It compares them with values computed from the line length, the window position, the lead and the ceiling of 360*65536/`bit_step`.

// File: rtl/ttx_pkg.sv
// Package: shared constants for the teletext insertion window controller.
// Assumes: the window length is fixed by the teletext line format, not programmable.
package ttx_pkg;
    // Bit periods in one insertion window, clock run-in included.
    localparam int TTX_WIN_BITS = 360;
    // Width of a counter that must hold 0..TTX_WIN_BITS.
    localparam int TTX_BIT_CW = $clog2(TTX_WIN_BITS + 1);
endpackage

// File: rtl/ttx_line_qualify.sv
// Module: ttx_line_qualify
// Decides combinationally whether the presented line may carry teletext.
// The line must lie inside the current field's first/last range, inside the
// mask coverage, and have its mask bit set.
// Assumes: $clog2(MASK_LINES) <= LINE_W; the inputs are held steady around the strobe.
module ttx_line_qualify #(
    parameter int LINE_W     = 10,
    parameter int MASK_LINES = 20,
    parameter int MASK_BASE  = 5
) (
    input  logic                  field_even,
    input  logic [LINE_W-1:0]     line_no,
    input  logic [LINE_W-1:0]     odd_first,
    input  logic [LINE_W-1:0]     odd_last,
    input  logic [LINE_W-1:0]     even_first,
    input  logic [LINE_W-1:0]     even_last,
    input  logic [MASK_LINES-1:0] line_mask,
    output logic                  line_ok
);
    localparam int IDX_W = (MASK_LINES > 1) ? $clog2(MASK_LINES) : 1;
    localparam int PAD_N = 1 << IDX_W;

    logic [PAD_N-1:0]  mask_pad;
    logic [LINE_W-1:0] range_lo;
    logic [LINE_W-1:0] range_hi;
    logic [LINE_W-1:0] mask_off;
    logic              in_range;
    logic              covered;
    logic              mask_hit;

    // Pad the mask to a power of two so any index of IDX_W bits is legal.
    generate
        if (PAD_N > MASK_LINES) begin : g_pad
            assign mask_pad = {{(PAD_N - MASK_LINES){1'b0}}, line_mask};
        end else begin : g_nopad
            assign mask_pad = line_mask;
        end
    endgenerate

    // Pick the current field's range and test the line against range and mask.
    always_comb begin
        range_lo = field_even ? even_first : odd_first;
        range_hi = field_even ? even_last  : odd_last;
        in_range = (line_no >= range_lo) && (line_no <= range_hi);
        mask_off = line_no - LINE_W'(MASK_BASE);
        covered  = (line_no >= LINE_W'(MASK_BASE)) && (mask_off < LINE_W'(MASK_LINES));
        mask_hit = covered && mask_pad[mask_off[IDX_W-1:0]];
        line_ok  = in_range && mask_hit;
    end
endmodule

// File: rtl/ttx_bit_clock.sv
// Module: ttx_bit_clock
// Fractional divider: a phase accumulator adds `step` in each cycle that `run`
// is high, and a carry out of the top bit is one teletext bit tick.
// Assumes: `clear` and `run` are never needed together; `clear` takes priority.
module ttx_bit_clock #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [ACC_W-1:0] step,
    output logic             tick
);
    logic [ACC_W-1:0] phase_q;
    logic [ACC_W:0]   phase_sum;

    // Next phase with carry; the carry marks a bit boundary.
    always_comb begin
        phase_sum = {1'b0, phase_q} + {1'b0, step};
        tick      = run && phase_sum[ACC_W];
    end

    // Phase register: cleared at line start, advanced only inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clear) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= phase_sum[ACC_W-1:0];
        end
    end
endmodule

// File: rtl/ttx_window_seq.sv
// Module: ttx_window_seq
// Per-line sequencer. It latches the line verdict at the strobe, counts pixels
// and window bits, and decodes the request and the gate.
// Assumes: the window settings are stable through a line; `bit_tick` is high
// only while `gate` is high.
module ttx_window_seq #(
    parameter int PIX_W    = 12,
    parameter int WIN_BITS = 360,
    parameter int BIT_CW   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_strobe,
    input  logic             line_ok,
    input  logic [PIX_W-1:0] req_lead,
    input  logic [PIX_W-1:0] win_open,
    input  logic [PIX_W-1:0] line_len,
    input  logic             bit_tick,
    output logic             req,
    output logic             gate
);
    logic              elig_q;
    logic [PIX_W-1:0]  pix_q;
    logic [BIT_CW-1:0] bits_q;
    logic [PIX_W-1:0]  req_start;
    logic              in_line;
    logic              bits_left;

    // Line verdict: taken once per line at the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elig_q <= 1'b0;
        end else if (line_strobe) begin
            elig_q <= line_ok;
        end
    end

    // Pixel index: zero after the strobe, saturating so it cannot wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_q <= '0;
        end else if (line_strobe) begin
            pix_q <= '0;
        end else if (pix_q != {PIX_W{1'b1}}) begin
            pix_q <= pix_q + 1'b1;
        end
    end

    // Window bit count: cleared per line, one step per bit tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (line_strobe) begin
            bits_q <= '0;
        end else if (bit_tick) begin
            bits_q <= bits_q + 1'b1;
        end
    end

    // Decode the request and gate from the pixel index and the bit count.
    always_comb begin
        req_start = (req_lead > win_open) ? '0 : (win_open - req_lead);
        in_line   = pix_q < line_len;
        bits_left = bits_q < BIT_CW'(WIN_BITS);
        gate      = elig_q && in_line && bits_left && (pix_q >= win_open);
        req       = elig_q && in_line && bits_left && (pix_q >= req_start);
    end
endmodule

// File: rtl/ttx_insert_ctrl.sv
// Module: ttx_insert_ctrl (top)
// Teletext insertion window controller: line qualification, per-line window
// sequencing and the fractional bit-rate tick.
// Assumes: one line_strobe per line; the settings change only between lines.
module ttx_insert_ctrl
    import ttx_pkg::*;
#(
    parameter int LINE_W     = 10,
    parameter int PIX_W      = 12,
    parameter int ACC_W      = 16,
    parameter int MASK_LINES = 20,
    parameter int MASK_BASE  = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  line_strobe,
    input  logic [LINE_W-1:0]     line_no,
    input  logic                  field_even,
    input  logic [LINE_W-1:0]     odd_first,
    input  logic [LINE_W-1:0]     odd_last,
    input  logic [LINE_W-1:0]     even_first,
    input  logic [LINE_W-1:0]     even_last,
    input  logic [MASK_LINES-1:0] line_mask,
    input  logic [PIX_W-1:0]      req_lead,
    input  logic [PIX_W-1:0]      win_open,
    input  logic [PIX_W-1:0]      line_len,
    input  logic [ACC_W-1:0]      bit_step,
    output logic                  ttx_req,
    output logic                  ttx_gate,
    output logic                  ttx_bit_tick
);
    logic line_ok;
    logic gate_w;
    logic tick_w;

    ttx_line_qualify #(
        .LINE_W     (LINE_W),
        .MASK_LINES (MASK_LINES),
        .MASK_BASE  (MASK_BASE)
    ) u_qualify (
        .field_even (field_even),
        .line_no    (line_no),
        .odd_first  (odd_first),
        .odd_last   (odd_last),
        .even_first (even_first),
        .even_last  (even_last),
        .line_mask  (line_mask),
        .line_ok    (line_ok)
    );

    ttx_bit_clock #(
        .ACC_W (ACC_W)
    ) u_bitclk (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (line_strobe),
        .run   (gate_w),
        .step  (bit_step),
        .tick  (tick_w)
    );

    ttx_window_seq #(
        .PIX_W    (PIX_W),
        .WIN_BITS (TTX_WIN_BITS),
        .BIT_CW   (TTX_BIT_CW)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_strobe (line_strobe),
        .line_ok     (line_ok),
        .req_lead    (req_lead),
        .win_open    (win_open),
        .line_len    (line_len),
        .bit_tick    (tick_w),
        .req         (ttx_req),
        .gate        (gate_w)
    );

    assign ttx_gate     = gate_w;
    assign ttx_bit_tick = tick_w;
endmodule

// File: rtl/ttx_insert_ctrl_chk.sv
// Module: ttx_insert_ctrl_chk
// Assertion checker bound to ttx_insert_ctrl; it watches only the top-level ports.
// Assumes: the window settings are stable across a line strobe.
module ttx_insert_ctrl_chk
    import ttx_pkg::*;
#(
    parameter int PIX_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             line_strobe,
    input logic [PIX_W-1:0] win_open,
    input logic             ttx_req,
    input logic             ttx_gate,
    input logic             ttx_bit_tick
);
    logic [TTX_BIT_CW-1:0] ticks_seen;

    // Ticks observed since the last strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ticks_seen <= '0;
        end else if (line_strobe) begin
            ticks_seen <= '0;
        end else if (ttx_bit_tick) begin
            ticks_seen <= ticks_seen + 1'b1;
        end
    end

    // R8: a bit tick only occurs inside the window.
    a_r8_tick_in_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ttx_bit_tick |-> ttx_gate);

    // R6: the request covers every window cycle.
    a_r6_gate_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        ttx_gate |-> ttx_req);

    // R7: no line gets more than the fixed window of ticks.
    a_r7_tick_cap: assert property (@(posedge clk) disable iff (!rst_n)
        ttx_bit_tick |-> (ticks_seen < TTX_BIT_CW'(TTX_WIN_BITS)));

    // R9: a strobe leaves no window open at pixel 0 unless the window opens there.
    a_r9_strobe_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (line_strobe && (win_open != '0)) |=> !ttx_gate);

    // R10: when the window closes within a line, the request drops with it.
    a_r10_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ttx_gate) && !ttx_gate && !$past(line_strobe)) |-> !ttx_req);
endmodule

bind ttx_insert_ctrl ttx_insert_ctrl_chk #(.PIX_W(PIX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_strobe  (line_strobe),
    .win_open     (win_open),
    .ttx_req      (ttx_req),
    .ttx_gate     (ttx_gate),
    .ttx_bit_tick (ttx_bit_tick)
);

// File: tb/ttx_insert_ctrl_bench.sv
`timescale 1ns/1ps
// Bench for ttx_insert_ctrl: a vector table of lines, then directed tests.
module ttx_insert_ctrl_bench;
    localparam int LINE_W = 10;
    localparam int PIX_W  = 12;
    localparam int ACC_W  = 16;
    localparam int MLINES = 20;
    localparam int MBASE  = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              line_strobe = 1'b0;
    logic [LINE_W-1:0] line_no = '0;
    logic              field_even = 1'b0;
    logic [LINE_W-1:0] odd_first = 10'd7;
    logic [LINE_W-1:0] odd_last = 10'd15;
    logic [LINE_W-1:0] even_first = 10'd10;
    logic [LINE_W-1:0] even_last = 10'd22;
    logic [MLINES-1:0] line_mask = 20'hFDFEF;
    logic [PIX_W-1:0]  req_lead = '0;
    logic [PIX_W-1:0]  win_open = '0;
    logic [PIX_W-1:0]  line_len = '0;
    logic [ACC_W-1:0]  bit_step = '0;
    logic              ttx_req;
    logic              ttx_gate;
    logic              ttx_bit_tick;

    ttx_insert_ctrl u_ttx_insert_ctrl (
        .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .line_no(line_no),
        .field_even(field_even), .odd_first(odd_first), .odd_last(odd_last),
        .even_first(even_first), .even_last(even_last), .line_mask(line_mask),
        .req_lead(req_lead), .win_open(win_open), .line_len(line_len),
        .bit_step(bit_step), .ttx_req(ttx_req), .ttx_gate(ttx_gate),
        .ttx_bit_tick(ttx_bit_tick)
    );

    always #10 clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    int c_req, c_gate, c_tick, f_req, f_gate;

    // Table columns: field_even, line, step, lead, open, len.
    localparam int NV = 8;
    localparam int V_EVEN [NV] = '{0, 1, 0, 0, 0, 1, 0, 1};
    localparam int V_LINE [NV] = '{12, 20, 20, 9, 6, 16, 7, 22};
    localparam int V_STEP [NV] = '{32768, 16384, 32768, 32768, 32768, 32768, 21846, 65535};
    localparam int V_LEAD [NV] = '{8, 100, 8, 8, 8, 4, 0, 2};
    localparam int V_OPEN [NV] = '{40, 50, 40, 40, 40, 300, 10, 0};
    localparam int V_LEN  [NV] = '{900, 1600, 900, 900, 900, 700, 1200, 400};

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Expected line verdict from the range and mask rules (R2-R5).
    function automatic int exp_elig(input int ev, input int ln);
        int lo, hi;
        bit cov;
        lo = ev ? int'(even_first) : int'(odd_first);
        hi = ev ? int'(even_last)  : int'(odd_last);
        cov = (ln >= MBASE) && (ln < MBASE + MLINES);
        if (!cov) return 0;
        return ((ln >= lo) && (ln <= hi) && line_mask[ln - MBASE]) ? 1 : 0;
    endfunction

    // Strobe one line, then sample `samples` pixels at falling edges.
    task automatic run_line(input int ev, input int ln, input int st, input int ld,
                            input int op, input int len, input int samples);
        @(negedge clk);
        field_even = ev[0]; line_no = LINE_W'(ln); bit_step = ACC_W'(st);
        req_lead = PIX_W'(ld); win_open = PIX_W'(op); line_len = PIX_W'(len);
        line_strobe = 1'b1;
        @(negedge clk);
        line_strobe = 1'b0;
        c_req = 0; c_gate = 0; c_tick = 0; f_req = -1; f_gate = -1;
        for (int k = 0; k < samples; k++) begin
            if (ttx_req) begin c_req++; if (f_req < 0) f_req = k; end
            if (ttx_gate) begin c_gate++; if (f_gate < 0) f_gate = k; end
            if (ttx_bit_tick) c_tick++;
            if (k != samples - 1) @(negedge clk);
        end
    endtask

    // Compare the counts of one full line with the values the requirements give.
    task automatic check_line(input string tag, input int ev, input int ln, input int st,
                              input int ld, input int op, input int len);
        longint n360, gend, gn, tk, rs, rn;
        int el;
        el = exp_elig(ev, ln);
        check({tag, " eligibility"}, (c_req > 0 || c_gate > 0) ? 1 : 0, el);
        if (el == 0) begin
            check("R4 R9 no gate", c_gate, 0);
            check("R8 no tick", c_tick, 0);
            return;
        end
        n360 = (360 * 65536 + longint'(st) - 1) / longint'(st);
        gend = (op + n360 < len) ? op + n360 : len;
        gn   = (gend > op) ? gend - op : 0;
        tk   = (gn * st) / 65536;
        if (tk > 360) tk = 360;
        rs   = (ld > op) ? 0 : op - ld;
        rn   = (gend > rs) ? gend - rs : 0;
        check("R7 R9 gate cycles", c_gate, int'(gn));
        check("R7 R8 tick count", c_tick, int'(tk));
        check("R10 request cycles", c_req, int'(rn));
        check("R6 first gate pixel", f_gate, (gn > 0) ? op : -1);
        check("R6 first request pixel", f_req, (rn > 0) ? int'(rs) : -1);
    endtask

    function automatic string row_tag(input int i);
        case (i)
            0: return "R2";
            1: return "R6";
            2: return "R3";
            3: return "R4";
            4: return "R4";
            5: return "R9";
            6: return "R8";
            default: return "R7";
        endcase
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: outputs are idle during reset.
        repeat (4) @(negedge clk);
        check("R1 req in reset", int'(ttx_req), 0);
        check("R1 gate in reset", int'(ttx_gate), 0);
        check("R1 tick in reset", int'(ttx_bit_tick), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle after reset", int'(ttx_req | ttx_gate | ttx_bit_tick), 0);

        // Vector table.
        for (int i = 0; i < NV; i++) begin
            run_line(V_EVEN[i], V_LINE[i], V_STEP[i], V_LEAD[i], V_OPEN[i], V_LEN[i], V_LEN[i] + 10);
            check_line(row_tag(i), V_EVEN[i], V_LINE[i], V_STEP[i], V_LEAD[i], V_OPEN[i], V_LEN[i]);
        end

        // R9: a strobe mid-window to an ineligible line leaves nothing open.
        run_line(0, 12, 32768, 8, 40, 900, 100);
        check("R9 window open before cut", int'(ttx_gate), 1);
        run_line(0, 9, 32768, 8, 40, 900, 200);
        check("R9 no carryover gate", c_gate, 0);
        check("R9 no carryover req", c_req, 0);

        // R9: a strobe mid-window to an eligible line restarts a full window.
        run_line(0, 12, 32768, 8, 40, 900, 100);
        run_line(0, 12, 32768, 8, 40, 900, 910);
        check_line("R9", 0, 12, 32768, 8, 40, 900);

        // R5: a reversed odd range disables every odd line.
        odd_first = 10'd14; odd_last = 10'd8;
        run_line(0, 12, 32768, 8, 40, 900, 910);
        check("R5 reversed range line 12", c_gate + c_req, 0);
        run_line(0, 14, 32768, 8, 40, 900, 910);
        check("R5 reversed range line 14", c_gate + c_req, 0);
        // R5: a one-line range enables exactly that line.
        odd_first = 10'd12; odd_last = 10'd12;
        run_line(0, 12, 32768, 8, 40, 900, 910);
        check_line("R5", 0, 12, 32768, 8, 40, 900);
        run_line(0, 13, 32768, 8, 40, 900, 910);
        check("R5 single range neighbour", c_gate + c_req, 0);

        // R1: reset in the middle of a window clears the outputs.
        run_line(0, 12, 32768, 8, 40, 900, 100);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-window", int'(ttx_req | ttx_gate | ttx_bit_tick), 0);
        rst_n = 1'b1;
        c_gate = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            c_gate += int'(ttx_gate | ttx_req);
        end
        check("R1 idle until next strobe", c_gate, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule